// File: doc/BRIEF.md
# Buffered-Transmit Serial Peripheral Slave

This block is the receive-and-reply end of a four-wire serial peripheral link. It runs entirely on the local system clock. Each of the three incoming link signals (serial clock, active-low select and master-out data) passes through a small synchronizer chain, and the block then works on the synchronized copies. Two static configuration inputs pick the serial clock's idle level and which of the two edges of each clock cycle samples data. Bytes move most significant bit first.

The local host puts the next reply byte into a one-entry transmit holding register. The register is copied into the shift register only at the start of a byte, so a host write that lands while a byte is on the wire waits for the next byte. Each completed incoming byte is latched into a receive register and flagged until the host acknowledges it. The outgoing data bit and an output-enable are separate ports: the pad driver tri-states the line whenever the enable is low, and the enable is high only while the slave is selected.

Top module: `spi_slave_buf`

## Requirements
- R1: `miso_oe` is 1 only while the synchronized select is low and a byte frame has been opened by a select falling edge; whenever the synchronized select is high, `miso_oe` is 0.
- R2: `cfg_cpol` gives the serial clock idle level (0 = idle low, 1 = idle high). A leading edge is a transition away from that level and a trailing edge is a transition back to it.
- R3: With `cfg_cpha` = 0, a select falling edge copies the holding register into the shift register and puts its bit 7 on `miso_o` within three system clock cycles, before any serial clock edge; leading edges sample `mosi_in` and trailing edges present the next outgoing bit.
- R4: With `cfg_cpha` = 0, one byte is exchanged per select-low period: serial clock edges after the 8th sampling edge are ignored until select rises and falls again, and they raise no new `rx_full`.
- R5: With `cfg_cpha` = 1, the first leading edge of a byte loads the shift register and drives bit 7, later leading edges drive the following bits, trailing edges sample `mosi_in`, and further bytes follow while select stays low.
- R6: Every byte is 8 bits, sent and received most significant bit first, over 8 serial clock cycles.
- R7: The shift register is reloaded from the holding register only at a byte boundary; a host write during a byte does not alter the bits still to be sent and is the byte sent next.
- R8: `tx_empty` is 1 after reset, rises when the holding register is copied into the shift register, and goes to 0 in the cycle after a `tx_wr` (a write in the same cycle as a copy leaves it at 0).
- R9: On the 8th sampling edge the received byte appears on `rx_data` and `rx_full` rises; `rx_data` holds otherwise; `rx_rd` clears `rx_full` unless a new byte completes in the same cycle.
- R10: If select rises before the 8th sampling edge, the partial byte is dropped, the bit count restarts at zero, `rx_full` is not raised and the next byte is received whole.
- R11: After reset `rx_full` = 0, `tx_empty` = 1, `miso_oe` = 0 and `rx_data` = 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Sampling edge select: 0 = leading, 1 = trailing |
| sclk_in | input | 1 | Serial clock from the master, asynchronous |
| ss_n_in | input | 1 | Active-low slave select, asynchronous |
| mosi_in | input | 1 | Serial data from the master, asynchronous |
| miso_o | output | 1 | Outgoing serial data bit |
| miso_oe | output | 1 | Output enable for the outgoing data pad |
| tx_wr | input | 1 | Host write strobe for the holding register |
| tx_data | input | DATA_W | Host transmit byte |
| tx_empty | output | 1 | Holding register has been consumed |
| rx_rd | input | 1 | Host acknowledge of the received byte |
| rx_data | output | DATA_W | Last completed received byte |
| rx_full | output | 1 | A received byte awaits the host |

## Verification
The properties assume the configuration inputs change only while select is high, that the serial clock rests at its configured idle level when select falls, and that each serial clock phase lasts well over the three-cycle synchronizer latency with `mosi_in` steady across the sampling edge. The stimulus keeps every serial clock phase at eight system cycles, changes data half a phase away from the sampling edge, and switches modes only with select high and the clock parked at its new idle level.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_HOLD  = 2'd2
    } xfer_st_e;

    // Serial clock transitions relative to the idle level.
    typedef struct packed {
        logic lead;
        logic trail;
    } sclk_evt_t;

    // Per-edge role once the phase setting is applied.
    typedef struct packed {
        logic cap;
        logic drv;
    } edge_role_t;

    function automatic sclk_evt_t classify_edge(input logic now_lvl,
                                                input logic old_lvl,
                                                input logic idle_lvl);
        sclk_evt_t e;
        e.lead  = (now_lvl != old_lvl) && (now_lvl != idle_lvl);
        e.trail = (now_lvl != old_lvl) && (now_lvl == idle_lvl);
        return e;
    endfunction

    function automatic edge_role_t map_roles(input sclk_evt_t e,
                                             input logic late_sample);
        edge_role_t r;
        if (late_sample) begin
            r.cap = e.trail;
            r.drv = e.lead;
        end else begin
            r.cap = e.lead;
            r.drv = e.trail;
        end
        return r;
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int       W       = 3,
    parameter int       STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= RST_VAL;
        else     chain[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[g] <= RST_VAL;
            else     chain[g] <= chain[g-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_evt.sv
module spi_evt
    import spi_slave_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sclk_s,
    input  logic       ss_s,
    input  logic       cpol,
    input  logic       cpha,
    output edge_role_t roles,
    output logic       ss_fall
);
    logic sclk_old;
    logic ss_old;
    sclk_evt_t evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_old <= 1'b0;
            ss_old   <= 1'b1;
        end else begin
            sclk_old <= sclk_s;
            ss_old   <= ss_s;
        end
    end

    always_comb begin
        evt     = classify_edge(sclk_s, sclk_old, cpol);
        roles   = map_roles(evt, cpha);
        ss_fall = ss_old && !ss_s;
    end
endmodule

// File: rtl/spi_txbuf.sv
module spi_txbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              load,
    output logic [DATA_W-1:0] hold,
    output logic              empty
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold  <= '0;
            empty <= 1'b1;
        end else if (wr) begin
            hold  <= wdata;
            empty <= 1'b0;
        end else if (load) begin
            empty <= 1'b1;
        end
    end
endmodule

// File: rtl/spi_core.sv
module spi_core
    import spi_slave_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CW    = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpha,
    input  logic              ss_s,
    input  logic              ss_fall,
    input  edge_role_t        roles,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] hold,
    input  logic              rx_rd,
    output logic              load,
    output logic              byte_done,
    output logic [CW-1:0]     bit_cnt,
    output logic              miso_bit,
    output logic              miso_oe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full
);
    localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

    xfer_st_e          st;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic              cap_ev;
    logic              drv_ev;

    assign cap_ev    = (st == ST_SHIFT) && !ss_s && roles.cap;
    assign drv_ev    = (st == ST_SHIFT) && !ss_s && roles.drv;
    assign byte_done = cap_ev && (bit_cnt == LAST);
    assign load      = ((st == ST_IDLE) && ss_fall && !cpha) ||
                       (drv_ev && cpha && (bit_cnt == '0));
    assign miso_oe   = !ss_s && (st != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            bit_cnt  <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            miso_bit <= 1'b0;
            rx_data  <= '0;
            rx_full  <= 1'b0;
        end else begin
            if (byte_done)  rx_full <= 1'b1;
            else if (rx_rd) rx_full <= 1'b0;

            if (byte_done) rx_data <= {rx_sh[DATA_W-2:0], mosi_s};

            if (ss_s) begin
                st      <= ST_IDLE;
                bit_cnt <= '0;
            end else begin
                case (st)
                    ST_IDLE: begin
                        if (ss_fall) begin
                            st      <= ST_SHIFT;
                            bit_cnt <= '0;
                        end
                    end
                    ST_SHIFT: begin
                        if (cap_ev) begin
                            rx_sh <= {rx_sh[DATA_W-2:0], mosi_s};
                            if (bit_cnt == LAST) begin
                                bit_cnt <= '0;
                                st      <= cpha ? ST_SHIFT : ST_HOLD;
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    ST_HOLD: ;
                    default: st <= ST_IDLE;
                endcase
            end

            if (load) begin
                tx_sh    <= hold;
                miso_bit <= hold[DATA_W-1];
            end else if (drv_ev) begin
                tx_sh    <= {tx_sh[DATA_W-2:0], 1'b0};
                miso_bit <= tx_sh[DATA_W-2];
            end
        end
    end
endmodule

// File: rtl/spi_slave_buf.sv
module spi_slave_buf
    import spi_slave_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CW         = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              sclk_in,
    input  logic              ss_n_in,
    input  logic              mosi_in,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_empty,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full
);
    logic [2:0]        sync_q;
    logic              sclk_s;
    logic              ss_s;
    logic              mosi_s;
    edge_role_t        roles;
    logic              ss_fall;
    logic              load;
    logic              byte_done;
    logic [CW-1:0]     bit_cnt;
    logic [DATA_W-1:0] hold;

    spi_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sclk_in, ss_n_in, mosi_in}),
        .q   (sync_q)
    );

    assign sclk_s = sync_q[2];
    assign ss_s   = sync_q[1];
    assign mosi_s = sync_q[0];

    spi_evt u_evt (
        .clk     (clk),
        .rst     (rst),
        .sclk_s  (sclk_s),
        .ss_s    (ss_s),
        .cpol    (cfg_cpol),
        .cpha    (cfg_cpha),
        .roles   (roles),
        .ss_fall (ss_fall)
    );

    spi_txbuf #(.DATA_W(DATA_W)) u_txbuf (
        .clk   (clk),
        .rst   (rst),
        .wr    (tx_wr),
        .wdata (tx_data),
        .load  (load),
        .hold  (hold),
        .empty (tx_empty)
    );

    spi_core #(.DATA_W(DATA_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .cpha      (cfg_cpha),
        .ss_s      (ss_s),
        .ss_fall   (ss_fall),
        .roles     (roles),
        .mosi_s    (mosi_s),
        .hold      (hold),
        .rx_rd     (rx_rd),
        .load      (load),
        .byte_done (byte_done),
        .bit_cnt   (bit_cnt),
        .miso_bit  (miso_o),
        .miso_oe   (miso_oe),
        .rx_data   (rx_data),
        .rx_full   (rx_full)
    );
endmodule

// File: rtl/spi_slave_buf_chk.sv
module spi_slave_buf_chk #(
    parameter int DATA_W = 8,
    parameter int CW     = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              ss_s,
    input logic              miso_oe,
    input logic              load,
    input logic              byte_done,
    input logic [CW-1:0]     bit_cnt,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_full,
    input logic              rx_rd,
    input logic              tx_wr,
    input logic              tx_empty
);
    assert_miso_off_R1: assert property (@(posedge clk) disable iff (rst)
        ss_s |-> !miso_oe);

    assert_load_boundary_R7: assert property (@(posedge clk) disable iff (rst)
        load |-> (bit_cnt == '0));

    assert_empty_clear_R8: assert property (@(posedge clk) disable iff (rst)
        tx_wr |=> !tx_empty);

    assert_rx_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !byte_done |=> $stable(rx_data));

    assert_rx_set_R9: assert property (@(posedge clk) disable iff (rst)
        byte_done |=> rx_full);

    assert_rx_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (rx_rd && !byte_done) |=> !rx_full);

    assert_abort_R10: assert property (@(posedge clk) disable iff (rst)
        ss_s |=> (bit_cnt == '0));

    assert_no_done_deselected_R10: assert property (@(posedge clk) disable iff (rst)
        ss_s |-> !byte_done);
endmodule

bind spi_slave_buf spi_slave_buf_chk #(.DATA_W(DATA_W), .CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ss_s      (ss_s),
    .miso_oe   (miso_oe),
    .load      (load),
    .byte_done (byte_done),
    .bit_cnt   (bit_cnt),
    .rx_data   (rx_data),
    .rx_full   (rx_full),
    .rx_rd     (rx_rd),
    .tx_wr     (tx_wr),
    .tx_empty  (tx_empty)
);

// File: tb/spi_slave_buf_tb.sv
module spi_slave_buf_tb;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_cpol = 1'b0;
    logic       cfg_cpha = 1'b0;
    logic       sclk_in = 1'b0;
    logic       ss_n_in = 1'b1;
    logic       mosi_in = 1'b0;
    logic       miso_o;
    logic       miso_oe;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_empty;
    logic       rx_rd = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full;

    int         n_checks = 0;
    int         n_fail = 0;
    logic [7:0] got;
    logic [7:0] exp_rx [$];
    bit         finished = 1'b0;

    always #2 clk = ~clk;

    spi_slave_buf u_dut (
        .clk      (clk),
        .rst      (rst),
        .cfg_cpol (cfg_cpol),
        .cfg_cpha (cfg_cpha),
        .sclk_in  (sclk_in),
        .ss_n_in  (ss_n_in),
        .mosi_in  (mosi_in),
        .miso_o   (miso_o),
        .miso_oe  (miso_oe),
        .tx_wr    (tx_wr),
        .tx_data  (tx_data),
        .tx_empty (tx_empty),
        .rx_rd    (rx_rd),
        .rx_data  (rx_data),
        .rx_full  (rx_full)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [7:0] d);
        @(negedge clk);
        tx_wr = 1'b1;
        tx_data = d;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic set_mode(input logic pol, input logic pha);
        cfg_cpol = pol;
        cfg_cpha = pha;
        sclk_in = pol;
        tick(HALF);
    endtask

    task automatic select();
        ss_n_in = 1'b0;
        tick(HALF);
    endtask

    task automatic deselect();
        ss_n_in = 1'b1;
        tick(HALF);
    endtask

    // Master side: exchange bits hi..lo of m, collecting returned bits into got.
    task automatic shift_bits(input logic [7:0] m, input int hi, input int lo);
        for (int i = hi; i >= lo; i--) begin
            if (!cfg_cpha) begin
                mosi_in = m[i];
                tick(HALF);
                got[i] = miso_o;
                sclk_in = ~sclk_in;
                tick(HALF);
                sclk_in = ~sclk_in;
            end else begin
                sclk_in = ~sclk_in;
                tick(HALF / 2);
                mosi_in = m[i];
                tick(HALF / 2);
                got[i] = miso_o;
                sclk_in = ~sclk_in;
                tick(HALF);
            end
        end
        tick(HALF);
    endtask

    // Scoreboard monitor: every completed byte must match the queue head.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && rx_full) begin
                if (exp_rx.size() == 0) begin
                    chk("R9 unexpected rx_full", 32'(rx_data), 32'hFFFF_FFFF);
                end else begin
                    chk("R9 rx_data vs scoreboard", 32'(rx_data), 32'(exp_rx.pop_front()));
                end
                rx_rd = 1'b1;
                @(negedge clk);
                rx_rd = 1'b0;
                @(negedge clk);
                chk("R9 rx_full cleared by rx_rd", 32'(rx_full), 32'd0);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        tick(5);
        rst = 1'b0;
        tick(2);
        // R11 reset state
        chk("R11 rx_full", 32'(rx_full), 32'd0);
        chk("R11 tx_empty", 32'(tx_empty), 32'd1);
        chk("R11 miso_oe", 32'(miso_oe), 32'd0);
        chk("R11 rx_data", 32'(rx_data), 32'd0);

        // Mode CPOL=0 CPHA=0, basic byte (R3, R6, R8, R1)
        set_mode(1'b0, 1'b0);
        host_write(8'hA5);
        chk("R8 tx_empty low after write", 32'(tx_empty), 32'd0);
        select();
        chk("R1 miso_oe while selected", 32'(miso_oe), 32'd1);
        chk("R3 MSB before first edge", 32'(miso_o), 32'd1);
        chk("R8 tx_empty after load", 32'(tx_empty), 32'd1);
        exp_rx.push_back(8'h3C);
        shift_bits(8'h3C, 7, 0);
        chk("R6 byte returned msb first", 32'(got), 32'hA5);
        deselect();
        chk("R1 miso_oe off after deselect", 32'(miso_oe), 32'd0);

        // R7: write during a byte is held for the next one
        host_write(8'h5A);
        select();
        exp_rx.push_back(8'hE1);
        shift_bits(8'hE1, 7, 4);
        host_write(8'hC3);
        chk("R7 tx_empty after mid-byte write", 32'(tx_empty), 32'd0);
        shift_bits(8'hE1, 3, 0);
        chk("R7 current byte unaffected", 32'(got), 32'h5A);
        deselect();
        select();
        exp_rx.push_back(8'h42);
        shift_bits(8'h42, 7, 0);
        chk("R7 held write sent next", 32'(got), 32'hC3);

        // R4: extra edges in the same select period are ignored
        tick(20);
        shift_bits(8'hFF, 7, 0);
        tick(20);
        chk("R4 no second byte without reselect", 32'(rx_full), 32'd0);
        deselect();

        // R10: abort mid-byte
        host_write(8'h81);
        select();
        shift_bits(8'hF0, 7, 5);
        deselect();
        tick(20);
        chk("R10 partial byte dropped", 32'(rx_full), 32'd0);
        select();
        exp_rx.push_back(8'h6D);
        shift_bits(8'h6D, 7, 0);
        chk("R10 next byte aligned", 32'(got), 32'h81);
        deselect();

        // R2: CPOL=1, CPHA=0
        set_mode(1'b1, 1'b0);
        host_write(8'h96);
        select();
        chk("R2 R3 MSB with idle-high clock", 32'(miso_o), 32'd1);
        exp_rx.push_back(8'h17);
        shift_bits(8'h17, 7, 0);
        chk("R2 byte with idle-high clock", 32'(got), 32'h96);
        deselect();

        // R5: CPHA=1, CPOL=0, two bytes in one select period
        set_mode(1'b0, 1'b1);
        host_write(8'h11);
        select();
        exp_rx.push_back(8'hB4);
        shift_bits(8'hB4, 7, 0);
        chk("R5 first byte late sampling", 32'(got), 32'h11);
        chk("R8 tx_empty after cpha1 load", 32'(tx_empty), 32'd1);
        host_write(8'h2E);
        exp_rx.push_back(8'h4B);
        shift_bits(8'h4B, 7, 0);
        chk("R5 back-to-back byte", 32'(got), 32'h2E);
        deselect();

        // R5 with R2: CPHA=1, CPOL=1
        set_mode(1'b1, 1'b1);
        host_write(8'hD9);
        select();
        exp_rx.push_back(8'h72);
        shift_bits(8'h72, 7, 0);
        chk("R5 R2 idle-high late sampling", 32'(got), 32'hD9);
        deselect();

        tick(40);
        chk("R9 scoreboard drained", 32'(exp_rx.size()), 32'd0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule